// File: doc/BRIEF.md
# Banked Memory Timing Controller

This block takes single-word memory requests (read, full-word write, and byte-masked partial write) through a valid/ready port. Each request goes to one of eight independent banks. The block splits the word address into a bank field and an in-bank location built from quadrant, chip-half, row and column fields.

Each bank stays occupied for a fixed number of clock cycles after it accepts a request. The length depends on the operation. While a bank is occupied, requests addressed to it are held off by a low ready. Requests to other banks are still taken, one per cycle, so accesses to different banks overlap.

A partial write is done inside the bank. The bank reads the old word, replaces the bytes chosen by the mask, and writes the result back before it releases the bank. Read data returns on a response port after a fixed latency, so responses come out in the order the reads were accepted. Each bank owns a simple synchronous array.

Top module: `banked_mem_ctrl`

## Requirements
- R1: With the default parameters, the address `req_addr[11:0]` is decoded as follows, from the least significant bit up: bank `[2:0]`, column `[5:3]`, row `[8:6]`, chip-half `[9]`, quadrant `[11:10]`. Any two addresses that differ in any field hold independent words.
- R2: The chip-half bit selects between two separate halves of storage in every bank. A value of 1 selects the upper half and 0 the lower half. Writing through one half leaves the word at the same row, column, quadrant and bank in the other half unchanged.
- R3: `req_ready` is low while the bank named by `req_addr[2:0]` is occupied. When successive requests go to different idle banks, they are accepted on consecutive clock edges.
- R4: A read or full write accepted at clock edge k keeps its bank occupied. The earliest edge at which the same bank can accept again is k+6.
- R5: A partial write accepted at clock edge k keeps its bank occupied until edge k+12. The earliest edge at which the same bank can accept again is k+12.
- R6: For a read accepted at edge k, `rsp_valid` is high for exactly one cycle, the cycle that ends at edge k+5. `rsp_data` in that cycle holds the stored word. This is one cycle before the bank can accept again.
- R7: A full write (`req_op`=01) replaces all 32 bits of the addressed word.
- R8: A partial write (`req_op`=10) updates byte i (bits 8i+7..8i) from `req_wdata` where `req_bmask[i]`=1. Every other byte keeps its old value.
- R9: Read responses appear in acceptance order, one per accepted read, with no extra responses.
- R10: After reset, every bank is ready and `rsp_valid` is low.
- R11: Opcode encoding: 00 is read, 01 is full write, 10 is partial write. Code 11 is handled as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank can accept this cycle |
| req_addr | input | 12 | Word address (bank, column, row, chip-half, quadrant) |
| req_op | input | 2 | Operation code |
| req_wdata | input | 32 | Write data |
| req_bmask | input | 4 | Byte mask for partial writes |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |

## Verification
The effects of a wrong internal state reach the ports as follows:
- **Wrong occupancy counter:** `req_ready` rises too early or too late. The bench checks ready against its own per-bank free-edge model on every cycle it drives a request, so the error appears within one cycle of the first affected request.
- **Wrong bank selection or response delay line:** the response arrives on the wrong edge, carries another bank's word, or breaks the acceptance order. Each of these is caught when the response appears, 5 cycles after acceptance.
- **Merge error in a partial write:** this stays hidden until the word is read back. The bench reads merged words soon after the bank frees, so the error shows within about 17 cycles.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_FULL  = 2'b01,
    OP_MERGE = 2'b10,
    OP_ALT   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    K_READ = 2'd0,
    K_FULL = 2'd1,
    K_PART = 2'd2
  } kind_e;

  function automatic kind_e decode_op(input logic [1:0] op);
    case (op)
      2'b01:   decode_op = K_FULL;
      2'b10:   decode_op = K_PART;
      default: decode_op = K_READ;
    endcase
  endfunction

endpackage

// File: rtl/bmc_addr_split.sv
module bmc_addr_split #(
  parameter int BANK_W = 3,
  parameter int COL_W  = 3,
  parameter int ROW_W  = 3,
  parameter int QUAD_W = 2,
  localparam int ADDR_W = BANK_W + COL_W + ROW_W + 1 + QUAD_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              half_o,
  output logic [QUAD_W-1:0] quad_o
);
  localparam int COL_LO  = BANK_W;
  localparam int ROW_LO  = COL_LO + COL_W;
  localparam int HALF_LO = ROW_LO + ROW_W;
  localparam int QUAD_LO = HALF_LO + 1;

  assign bank_o = addr_i[BANK_W-1:0];
  assign col_o  = addr_i[COL_LO +: COL_W];
  assign row_o  = addr_i[ROW_LO +: ROW_W];
  assign half_o = addr_i[HALF_LO];
  assign quad_o = addr_i[QUAD_LO +: QUAD_W];
endmodule

// File: rtl/bmc_bank_array.sv
module bmc_bank_array #(
  parameter int AW = 9,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
      else      rdata_o     <= mem[addr_i];
    end
  end
endmodule

// File: rtl/bmc_bank.sv
module bmc_bank
  import bmc_pkg::*;
#(
  parameter int AW         = 9,
  parameter int DW         = 32,
  parameter int PLAIN_BUSY = 6,
  parameter int PART_BUSY  = 12,
  localparam int NBYTE = DW / 8,
  localparam int CW    = $clog2(PART_BUSY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  kind_e            kind_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NBYTE-1:0] bmask_i,
  output logic             ready_o,
  output logic [DW-1:0]    rdata_o
);
  localparam logic [CW-1:0] PLAIN_LOAD = CW'(PLAIN_BUSY - 1);
  localparam logic [CW-1:0] PART_LOAD  = CW'(PART_BUSY - 1);
  localparam logic [CW-1:0] WB_POINT   = CW'(1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             merge_q, merge_d;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [NBYTE-1:0] mask_q;
  logic             hold_en;

  logic             arr_en, arr_we;
  logic [AW-1:0]    arr_addr;
  logic [DW-1:0]    arr_wdata, merged;
  logic             do_wb;

  assign hold_en = acc_i;
  assign do_wb   = merge_q && (cnt_q == WB_POINT);

  always_comb begin
    cnt_d   = cnt_q;
    merge_d = merge_q;
    if (acc_i) begin
      cnt_d   = (kind_i == K_PART) ? PART_LOAD : PLAIN_LOAD;
      merge_d = (kind_i == K_PART);
    end else begin
      if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
      if (do_wb)       merge_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      merge_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      merge_q <= merge_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) begin
      addr_q  <= waddr_i;
      wdata_q <= wdata_i;
      mask_q  <= bmask_i;
    end
  end

  always_comb begin
    for (int i = 0; i < NBYTE; i++) begin
      merged[i*8 +: 8] = mask_q[i] ? wdata_q[i*8 +: 8] : rdata_o[i*8 +: 8];
    end
  end

  always_comb begin
    arr_en    = 1'b0;
    arr_we    = 1'b0;
    arr_addr  = waddr_i;
    arr_wdata = wdata_i;
    if (acc_i) begin
      arr_en = 1'b1;
      arr_we = (kind_i == K_FULL);
    end else if (do_wb) begin
      arr_en    = 1'b1;
      arr_we    = 1'b1;
      arr_addr  = addr_q;
      arr_wdata = merged;
    end
  end

  bmc_bank_array #(.AW(AW), .DW(DW)) u_array (
    .clk     (clk),
    .en_i    (arr_en),
    .we_i    (arr_we),
    .addr_i  (arr_addr),
    .wdata_i (arr_wdata),
    .rdata_o (rdata_o)
  );

  assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/bmc_rsp_pipe.sv
module bmc_rsp_pipe #(
  parameter int NB       = 8,
  parameter int BW       = 3,
  parameter int DW       = 32,
  parameter int READ_LAT = 5,
  localparam int ST = READ_LAT - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_i,
  input  logic [BW-1:0]  bank_i,
  input  logic [NB*DW-1:0] bank_rdata_i,
  output logic           rsp_valid_o,
  output logic [DW-1:0]  rsp_data_o
);
  logic [ST-1:0] vld_q, vld_d;
  logic [BW-1:0] bid_q [ST];
  logic [BW-1:0] bid_d [ST];
  logic          out_v_d;
  logic          data_en;
  logic [DW-1:0] data_d;

  always_comb begin
    vld_d[0] = push_i;
    bid_d[0] = bank_i;
    for (int i = 1; i < ST; i++) begin
      vld_d[i] = vld_q[i-1];
      bid_d[i] = bid_q[i-1];
    end
    out_v_d = vld_q[ST-1];
    data_en = vld_q[ST-1];
    data_d  = bank_rdata_i[bid_q[ST-1]*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q       <= '0;
      rsp_valid_o <= 1'b0;
    end else begin
      vld_q       <= vld_d;
      rsp_valid_o <= out_v_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ST; i++) bid_q[i] <= bid_d[i];
    if (data_en) rsp_data_o <= data_d;
  end
endmodule

// File: rtl/banked_mem_ctrl.sv
module banked_mem_ctrl
  import bmc_pkg::*;
#(
  parameter int BANK_W     = 3,
  parameter int COL_W      = 3,
  parameter int ROW_W      = 3,
  parameter int QUAD_W     = 2,
  parameter int DATA_W     = 32,
  parameter int READ_LAT   = 5,
  parameter int PLAIN_BUSY = 6,
  parameter int PART_BUSY  = 12,
  localparam int ADDR_W    = BANK_W + COL_W + ROW_W + 1 + QUAD_W,
  localparam int WAW       = ADDR_W - BANK_W,
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int NBYTE     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NBYTE-1:0]  req_bmask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [BANK_W-1:0]    f_bank;
  logic [COL_W-1:0]     f_col;
  logic [ROW_W-1:0]     f_row;
  logic                 f_half;
  logic [QUAD_W-1:0]    f_quad;
  logic [WAW-1:0]       word_idx;
  kind_e                kind;
  logic                 accept;
  logic [NUM_BANKS-1:0] bank_ready;
  logic [NUM_BANKS-1:0] bank_acc;
  logic [NUM_BANKS*DATA_W-1:0] bank_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bmc_addr_split #(
    .BANK_W(BANK_W), .COL_W(COL_W), .ROW_W(ROW_W), .QUAD_W(QUAD_W)
  ) u_split (
    .addr_i (req_addr),
    .bank_o (f_bank),
    .col_o  (f_col),
    .row_o  (f_row),
    .half_o (f_half),
    .quad_o (f_quad)
  );

  assign word_idx  = {f_quad, f_half, f_row, f_col};
  assign kind      = decode_op(req_op);
  assign req_ready = rst_int_n && bank_ready[f_bank];
  assign accept    = req_valid && req_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_acc[b] = accept && (f_bank == BANK_W'(b));

    bmc_bank #(
      .AW(WAW), .DW(DATA_W), .PLAIN_BUSY(PLAIN_BUSY), .PART_BUSY(PART_BUSY)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .acc_i   (bank_acc[b]),
      .kind_i  (kind),
      .waddr_i (word_idx),
      .wdata_i (req_wdata),
      .bmask_i (req_bmask),
      .ready_o (bank_ready[b]),
      .rdata_o (bank_rdata[b*DATA_W +: DATA_W])
    );
  end

  bmc_rsp_pipe #(
    .NB(NUM_BANKS), .BW(BANK_W), .DW(DATA_W), .READ_LAT(READ_LAT)
  ) u_rsp (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .push_i       (accept && (kind == K_READ)),
    .bank_i       (f_bank),
    .bank_rdata_i (bank_rdata),
    .rsp_valid_o  (rsp_valid),
    .rsp_data_o   (rsp_data)
  );
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
  parameter int BANK_W     = 3,
  parameter int ADDR_W     = 12,
  parameter int READ_LAT   = 5,
  parameter int PLAIN_BUSY = 6,
  parameter int PART_BUSY  = 12,
  localparam int NB = 1 << BANK_W,
  localparam int CW = $clog2(PART_BUSY + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_op,
  input logic              rsp_valid,
  input logic [NB-1:0]     bank_ready
);
  logic              acc;
  logic              acc_rd;
  logic [BANK_W-1:0] bsel;
  logic [READ_LAT-1:0] sh;
  logic [CW-1:0]     occ [NB];

  assign acc    = req_valid && req_ready;
  assign bsel   = req_addr[BANK_W-1:0];
  assign acc_rd = acc && (req_op != 2'b01) && (req_op != 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[READ_LAT-2:0], acc_rd};
  end

  for (genvar b = 0; b < NB; b++) begin : g_occ
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ[b] <= '0;
      else if (acc && bsel == BANK_W'(b))
        occ[b] <= (req_op == 2'b10) ? CW'(PART_BUSY - 1) : CW'(PLAIN_BUSY - 1);
      else if (occ[b] != '0)
        occ[b] <= occ[b] - CW'(1);
    end

    // R4 and R5: ready tracks an independently counted occupancy window
    assert_busy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bank_ready[b] == (occ[b] == '0));
  end

  assert_stall_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !bank_ready[$past(bsel)]);

  assert_rsp_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == sh[READ_LAT-1]);

  assert_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rsp_valid && (&bank_ready)));
endmodule

bind banked_mem_ctrl bmc_checker #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .READ_LAT(READ_LAT),
  .PLAIN_BUSY(PLAIN_BUSY), .PART_BUSY(PART_BUSY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_op     (req_op),
  .rsp_valid  (rsp_valid),
  .bank_ready (bank_ready)
);

// File: tb/banked_mem_ctrl_tb.sv
`timescale 1ns/1ps
module banked_mem_ctrl_tb;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_op;
  logic [DW-1:0] req_wdata;
  logic [3:0]    req_bmask;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;

  logic [DW-1:0] ref_mem [4096];
  bit            ref_ok  [4096];
  int            free_edge [8];
  logic [DW-1:0] exp_q [$];
  int            exp_e [$];

  banked_mem_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_op(req_op), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] merge_ref(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                              input logic [3:0] m);
    logic [DW-1:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = m[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction

  // Response monitor: order, timing and data (R6, R9, R1, R2, R7, R8)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_data, 0);
      end else begin
        logic [DW-1:0] ed;
        int ee;
        ed = exp_q.pop_front();
        ee = exp_e.pop_front();
        check(cyc == ee + 4, "R6 response timing", cyc, ee + 4);
        check(rsp_data === ed, "R6 response data", rsp_data, ed);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Drive a request, wait for acceptance, update the model; returns acceptance edge
  task automatic issue(input logic [AW-1:0] a, input logic [1:0] op, input logic [DW-1:0] wd,
                       input logic [3:0] bm, output int acc_edge);
    int b;
    b = int'(a[2:0]);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_op = op; req_wdata = wd; req_bmask = bm;
    forever begin
      #1;
      check(req_ready == ((cyc + 1) >= free_edge[b]), "R3 ready vs bank occupancy",
            req_ready, ((cyc + 1) >= free_edge[b]));
      if (req_ready) break;
      @(negedge clk);
    end
    acc_edge = cyc + 1;
    case (op)
      2'b01: begin
        ref_mem[a] = wd; ref_ok[a] = 1'b1;
        free_edge[b] = acc_edge + 6;
      end
      2'b10: begin
        ref_mem[a] = merge_ref(ref_mem[a], wd, bm);
        free_edge[b] = acc_edge + 12;
      end
      default: begin
        exp_q.push_back(ref_mem[a]); exp_e.push_back(acc_edge);
        free_edge[b] = acc_edge + 6;
      end
    endcase
    @(posedge clk);
  endtask

  initial begin
    int e0, e1, n;
    logic [AW-1:0] pool [32];
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_op = '0; req_wdata = '0; req_bmask = '0;
    for (int i = 0; i < 8; i++) free_edge[i] = 0;
    for (int i = 0; i < 4096; i++) ref_ok[i] = 1'b0;
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: all banks ready, no response after reset
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); req_addr = AW'(b); #1;
      check(req_ready == 1'b1, "R10 bank ready after reset", req_ready, 1);
    end
    check(rsp_valid == 1'b0, "R10 no response after reset", rsp_valid, 0);

    // R1/R2/R7: fields are independent; chip-half selects separate storage
    issue(12'h003, 2'b01, 32'h1111_0000, 4'h0, e0);
    issue(12'h00B, 2'b01, 32'h2222_0001, 4'h0, e0); // column bit
    issue(12'h043, 2'b01, 32'h3333_0002, 4'h0, e0); // row bit
    issue(12'h203, 2'b01, 32'h4444_0003, 4'h0, e0); // chip-half (R2)
    issue(12'h403, 2'b01, 32'h5555_0004, 4'h0, e0); // quadrant
    issue(12'h004, 2'b01, 32'h6666_0005, 4'h0, e0); // other bank
    issue(12'h003, 2'b00, 32'h0, 4'h0, e0);
    issue(12'h00B, 2'b00, 32'h0, 4'h0, e0);
    issue(12'h043, 2'b00, 32'h0, 4'h0, e0);
    issue(12'h203, 2'b00, 32'h0, 4'h0, e0);
    issue(12'h403, 2'b00, 32'h0, 4'h0, e0);
    issue(12'h004, 2'b00, 32'h0, 4'h0, e0);

    // R4: plain access occupies its bank for six edges
    idle(); repeat (14) @(posedge clk);
    issue(12'h012, 2'b01, 32'hCAFE_F00D, 4'h0, e0);
    issue(12'h012, 2'b00, 32'h0, 4'h0, e1);
    check(e1 - e0 == 6, "R4 write-to-read spacing", e1 - e0, 6);
    issue(12'h012, 2'b00, 32'h0, 4'h0, e0);
    check(e0 - e1 == 6, "R4 read-to-read spacing", e0 - e1, 6);

    // R5/R8: partial write occupies twelve edges and merges bytes
    issue(12'h012, 2'b10, 32'hA1B2_C3D4, 4'b0101, e0);
    issue(12'h012, 2'b00, 32'h0, 4'h0, e1);
    check(e1 - e0 == 12, "R5 partial write spacing", e1 - e0, 12);
    issue(12'h012, 2'b10, 32'h0F0F_0F0F, 4'b1000, e0);
    issue(12'h012, 2'b00, 32'h0, 4'h0, e1);
    issue(12'h012, 2'b10, 32'h7777_7777, 4'b0000, e0); // R8: empty mask keeps word
    issue(12'h012, 2'b00, 32'h0, 4'h0, e1);

    // R3/R9: different banks accept on consecutive edges, responses stay ordered
    idle(); repeat (14) @(posedge clk);
    for (int b = 0; b < 8; b++) issue(AW'(12'h100 | b), 2'b01, 32'hB0B0_0000 + b, 4'h0, e0);
    idle(); repeat (8) @(posedge clk);
    issue(12'h100, 2'b00, 32'h0, 4'h0, e0);
    for (int b = 1; b < 8; b++) begin
      issue(AW'(12'h100 | b), 2'b00, 32'h0, 4'h0, e1);
      check(e1 - e0 == 1, "R3 back-to-back across banks", e1 - e0, 1);
      e0 = e1;
    end

    // R11: code 11 behaves as a read
    issue(12'h105, 2'b11, 32'hFFFF_FFFF, 4'hF, e0);

    // Random phase on a small pool of addresses
    for (int i = 0; i < 32; i++) pool[i] = AW'($urandom);
    pool[1] = pool[0] ^ 12'h200;
    for (int i = 0; i < 32; i++) issue(pool[i], 2'b01, $urandom, 4'h0, e0);
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [1:0] op;
      a  = pool[$urandom % 32];
      op = 2'($urandom);
      issue(a, op, $urandom, 4'($urandom), e0);
      n = $urandom % 4;
      if (n == 0) begin idle(); repeat ($urandom % 3) @(posedge clk); end
    end
    idle();
    repeat (20) @(posedge clk);
    check(exp_q.size() == 0, "R9 every read answered", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule